// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block is a calendar clock that keeps seconds, minutes, hours, day of month, month, two-digit year and weekday as packed BCD bytes. A one-cycle pulse on `sec_tick` advances the calendar by one second, but only while the run bit in the control register is set. Software reaches the block over a byte-wide register bus. A write takes effect at the clock edge where `bus_wr` is high. A read returns its byte on `bus_rdata` one cycle after `bus_rd`, and that byte holds until the next read.

Reads of the time fields do not see the live counters. Setting the capture bit in the control register copies all seven counters into a shadow bank in one edge. Later reads then return one coherent time, even if the clock ticks while software reads the bytes one by one.

The status register holds sticky event flags (second, minute, hour, day, alarm and power-up), which are cleared by writing ones. A single level interrupt combines the alarm flag with one periodic event flag, and each source has its own enable.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the status register (offset 0x0E) reads 0x80, the control register (0x0D) and the interrupt register (0x0F) read 0x00, and `irq` is 0.
- R2: In 24-hour mode the seconds and minutes roll from 0x59 to 0x00, each carrying into the next field. The hour rolls from 0x23 to 0x00 and steps the day. All counting is in packed BCD.
- R3: The day of month (0x03) wraps to 0x01 after day 28, 29, 30 or 31. The limit depends on the month (0x04) and on a leap year, which is a year (0x05) divisible by 4. Month 0x12 wraps to 0x01 and steps the year. Year 0x99 wraps to 0x00.
- R4: The weekday (0x06) counts 0 to 6. It steps on every day change and wraps from 6 to 0.
- R5: When control bit 3 is 1 (12-hour mode), hour bit 7 is the PM flag and the hour counts 12, 1, ..., 11. Going from 11 to 12 toggles PM, and going from PM to AM steps the day.
- R6: Control bit 0 is the run bit. The counters advance only when it is 1 and `sec_tick` pulses. Writes to offsets 0x00–0x06 load the counters only while it is 0 and are ignored while it is 1.
- R7: Writing control bit 6 as 1 copies the live counters, as they stood before that edge, into the shadow bank. Reads of 0x00–0x06 return the shadow bank. Bit 6 reads back as 0.
- R8: Status bit 1 reads the run bit. On each advancing tick, status bit 2 is set. Bit 3 is set when the seconds wrap, bit 4 when the minutes wrap and bit 5 when the day changes. All of these flags are sticky.
- R9: Writing a 1 to status bits 2–7 clears those bits, and writing a 0 leaves them unchanged. A flag set by a tick in the same cycle as its clear stays set. The power-up flag (bit 7) is never set again after reset.
- R10: Status bit 6 (alarm) is set on an advancing tick when the new seconds, minutes, hours, day, month and year all equal the alarm registers at 0x07–0x0C.
- R11: `irq` is high exactly when either of two conditions holds. The first: status bit 6 and interrupt bit 3 are both set. The second: interrupt bit 2 is set and the event flag chosen by interrupt bits [1:0] is set, where 0 chooses second, 1 minute, 2 hour and 3 day.
- R12: The alarm registers and the two storage bytes at 0x10 and 0x11 read back as written. The interrupt register keeps bits [3:0] and reads 0 above them. Offsets above 0x11 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt |

## Verification
The hardest conditions to reach are the multi-field carries: a leap-day boundary, a year wrap on New Year's Eve and the PM-to-AM step in 12-hour mode. Counting up to any of them with ticks would take days of simulated seconds. The bench instead stops the clock, loads a time one second before the boundary, restarts it and gives a single tick. The same preload places the alarm two seconds ahead and puts a periodic minute event on a chosen tick. A tick is also driven in the same cycle as a status clear, to show that a newly set flag wins over the clear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int N_ALARM  = 6;
    localparam int N_TIME   = 7;

    typedef logic [DATA_W-1:0] byte_t;

    // field order: seconds first, weekday last
    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t mday;
        byte_t mon;
        byte_t year;
        byte_t wday;
    } cal_t;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_SEC   = 5'h00;
    localparam addr_t A_MIN   = 5'h01;
    localparam addr_t A_HOUR  = 5'h02;
    localparam addr_t A_MDAY  = 5'h03;
    localparam addr_t A_MON   = 5'h04;
    localparam addr_t A_YEAR  = 5'h05;
    localparam addr_t A_WDAY  = 5'h06;
    localparam addr_t A_ALM0  = 5'h07;
    localparam addr_t A_CTRL  = 5'h0D;
    localparam addr_t A_STAT  = 5'h0E;
    localparam addr_t A_IEN   = 5'h0F;
    localparam addr_t A_CMPL  = 5'h10;
    localparam addr_t A_CMPH  = 5'h11;

    localparam byte_t SEC_MAX  = 8'h59;
    localparam byte_t HOUR_MAX = 8'h23;
    localparam byte_t MON_MAX  = 8'h12;
    localparam byte_t YEAR_MAX = 8'h99;
    localparam byte_t WDAY_MAX = 8'h06;

    // bit positions used by the block's behaviour
    localparam int C_RUN  = 0;
    localparam int C_H12  = 3;
    localparam int C_SNAP = 6;
    localparam int S_RUN  = 1;
    localparam int S_SEC  = 2;
    localparam int S_MIN  = 3;
    localparam int S_HOUR = 4;
    localparam int S_DAY  = 5;
    localparam int S_ALM  = 6;
    localparam int S_PWR  = 7;

    function automatic byte_t bcd_inc(input byte_t v);
        byte_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

endpackage

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
    import rtc_pkg::*;
(
    input  cal_t cur_i,
    input  logic mode12_i,
    output cal_t nxt_o,
    output logic min_ev_o,
    output logic hour_ev_o,
    output logic day_ev_o
);

    logic       sec_wrap;
    logic       min_wrap;
    logic       day_step;
    logic       mday_wrap;
    logic       mon_wrap;
    logic       leap;
    byte_t      last_day;
    byte_t      h_inc;
    logic [4:0] h12;

    always_comb begin
        nxt_o    = cur_i;
        day_step = 1'b0;
        sec_wrap = (cur_i.sec >= SEC_MAX);
        min_wrap = sec_wrap && (cur_i.min >= SEC_MAX);
        h12      = cur_i.hour[4:0];
        h_inc    = bcd_inc({3'b000, h12});

        nxt_o.sec = sec_wrap ? '0 : bcd_inc(cur_i.sec);
        if (sec_wrap) nxt_o.min = min_wrap ? '0 : bcd_inc(cur_i.min);

        if (min_wrap) begin
            if (mode12_i) begin
                if (h12 == 5'h11) begin
                    nxt_o.hour = {~cur_i.hour[7], 2'b00, 5'h12};
                    day_step   = cur_i.hour[7];
                end else if (h12 == 5'h12) begin
                    nxt_o.hour = {cur_i.hour[7], 7'h01};
                end else begin
                    nxt_o.hour = {cur_i.hour[7], 2'b00, h_inc[4:0]};
                end
            end else if (cur_i.hour >= HOUR_MAX) begin
                nxt_o.hour = '0;
                day_step   = 1'b1;
            end else begin
                nxt_o.hour = bcd_inc(cur_i.hour);
            end
        end

        // tens digit odd: units 2 or 6; tens digit even: units 0, 4 or 8
        if (cur_i.year[4]) leap = (cur_i.year[3:0] == 4'd2) || (cur_i.year[3:0] == 4'd6);
        else               leap = (cur_i.year[3:0] == 4'd0) || (cur_i.year[3:0] == 4'd4)
                                  || (cur_i.year[3:0] == 4'd8);

        case (cur_i.mon)
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            default:                    last_day = 8'h31;
        endcase

        mday_wrap = day_step && (cur_i.mday >= last_day);
        mon_wrap  = mday_wrap && (cur_i.mon >= MON_MAX);

        if (day_step) begin
            nxt_o.mday = mday_wrap ? 8'h01 : bcd_inc(cur_i.mday);
            nxt_o.wday = (cur_i.wday >= WDAY_MAX) ? '0 : cur_i.wday + 8'd1;
        end
        if (mday_wrap) nxt_o.mon  = mon_wrap ? 8'h01 : bcd_inc(cur_i.mon);
        if (mon_wrap)  nxt_o.year = (cur_i.year >= YEAR_MAX) ? '0 : bcd_inc(cur_i.year);
    end

    assign min_ev_o  = sec_wrap;
    assign hour_ev_o = min_wrap;
    assign day_ev_o  = day_step;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int N_FIELD = 6,
    parameter int FW      = 8
) (
    input  logic [N_FIELD-1:0][FW-1:0] now_i,
    input  logic [N_FIELD-1:0][FW-1:0] ref_i,
    output logic                       hit_o
);

    logic [N_FIELD-1:0] eq;

    for (genvar g = 0; g < N_FIELD; g++) begin : g_cmp
        assign eq[g] = (now_i[g] == ref_i[g]);
    end

    assign hit_o = &eq;

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int AIX_W = $clog2(N_ALARM);

    typedef struct packed {
        cal_t                   live;
        cal_t                   shadow;
        logic [N_ALARM-1:0][DATA_W-1:0] alm;
        byte_t                  ctrl;
        byte_t                  stat;
        logic [3:0]             ien;
        byte_t                  cmp_lo;
        byte_t                  cmp_hi;
        byte_t                  rdata;
    } state_t;

    state_t state_q, state_d;

    cal_t  cal_nxt;
    logic  ev_min, ev_hour, ev_day;
    logic  alarm_hit;
    logic  advance;
    logic  per_ev;
    byte_t set_m, clr_m, rd_val;
    logic [AIX_W-1:0] aix;
    logic [N_ALARM-1:0][DATA_W-1:0] now_vec;

    rtc_cal_next u_next (
        .cur_i     (state_q.live),
        .mode12_i  (state_q.ctrl[C_H12]),
        .nxt_o     (cal_nxt),
        .min_ev_o  (ev_min),
        .hour_ev_o (ev_hour),
        .day_ev_o  (ev_day)
    );

    assign now_vec = {cal_nxt.year, cal_nxt.mon, cal_nxt.mday,
                      cal_nxt.hour, cal_nxt.min, cal_nxt.sec};

    rtc_alarm_match #(.N_FIELD(N_ALARM), .FW(DATA_W)) u_match (
        .now_i (now_vec),
        .ref_i (state_q.alm),
        .hit_o (alarm_hit)
    );

    always_comb begin
        state_d = state_q;
        advance = sec_tick && state_q.ctrl[C_RUN];
        set_m   = '0;
        clr_m   = '0;
        aix     = AIX_W'(bus_addr - A_ALM0);

        if (advance) begin
            state_d.live  = cal_nxt;
            set_m[S_SEC]  = 1'b1;
            set_m[S_MIN]  = ev_min;
            set_m[S_HOUR] = ev_hour;
            set_m[S_DAY]  = ev_day;
            set_m[S_ALM]  = alarm_hit;
        end

        if (bus_wr) begin
            if (bus_addr >= A_ALM0 && bus_addr < A_CTRL) begin
                state_d.alm[aix] = bus_wdata;
            end
            case (bus_addr)
                A_SEC:  if (!state_q.ctrl[C_RUN]) state_d.live.sec  = bus_wdata;
                A_MIN:  if (!state_q.ctrl[C_RUN]) state_d.live.min  = bus_wdata;
                A_HOUR: if (!state_q.ctrl[C_RUN]) state_d.live.hour = bus_wdata;
                A_MDAY: if (!state_q.ctrl[C_RUN]) state_d.live.mday = bus_wdata;
                A_MON:  if (!state_q.ctrl[C_RUN]) state_d.live.mon  = bus_wdata;
                A_YEAR: if (!state_q.ctrl[C_RUN]) state_d.live.year = bus_wdata;
                A_WDAY: if (!state_q.ctrl[C_RUN]) state_d.live.wday = bus_wdata;
                A_CTRL: begin
                    state_d.ctrl = {bus_wdata[7], 1'b0, bus_wdata[5:0]};
                    if (bus_wdata[C_SNAP]) state_d.shadow = state_q.live;
                end
                A_STAT: clr_m = bus_wdata;
                A_IEN:  state_d.ien = bus_wdata[3:0];
                A_CMPL: state_d.cmp_lo = bus_wdata;
                A_CMPH: state_d.cmp_hi = bus_wdata;
                default: ;
            endcase
        end

        state_d.stat = ((state_q.stat & ~clr_m) | set_m) & 8'hFC;

        rd_val = '0;
        if (bus_addr >= A_ALM0 && bus_addr < A_CTRL) rd_val = state_q.alm[aix];
        case (bus_addr)
            A_SEC:  rd_val = state_q.shadow.sec;
            A_MIN:  rd_val = state_q.shadow.min;
            A_HOUR: rd_val = state_q.shadow.hour;
            A_MDAY: rd_val = state_q.shadow.mday;
            A_MON:  rd_val = state_q.shadow.mon;
            A_YEAR: rd_val = state_q.shadow.year;
            A_WDAY: rd_val = state_q.shadow.wday;
            A_CTRL: rd_val = state_q.ctrl;
            A_STAT: rd_val = {state_q.stat[7:2], state_q.ctrl[C_RUN], 1'b0};
            A_IEN:  rd_val = {4'h0, state_q.ien};
            A_CMPL: rd_val = state_q.cmp_lo;
            A_CMPH: rd_val = state_q.cmp_hi;
            default: ;
        endcase
        if (bus_rd) state_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q             <= '0;
            state_q.live.mday   <= 8'h01;
            state_q.live.mon    <= 8'h01;
            state_q.shadow.mday <= 8'h01;
            state_q.shadow.mon  <= 8'h01;
            state_q.stat        <= 8'h80;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (state_q.ien[1:0])
            2'd0:    per_ev = state_q.stat[S_SEC];
            2'd1:    per_ev = state_q.stat[S_MIN];
            2'd2:    per_ev = state_q.stat[S_HOUR];
            default: per_ev = state_q.stat[S_DAY];
        endcase
    end

    assign irq       = (state_q.stat[S_ALM] & state_q.ien[3]) | (per_ev & state_q.ien[2]);
    assign bus_rdata = state_q.rdata;

    // R6: stopped clock with no time write keeps every counter
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.ctrl[C_RUN] && !(bus_wr && bus_addr <= A_WDAY)) |=> $stable(state_q.live))
        else $error("p_hold_r6");

    // R2: seconds stay a valid BCD value below 60
    p_sec_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.live.sec[3:0] <= 4'd9) && (state_q.live.sec <= SEC_MAX))
        else $error("p_sec_bcd_r2");

    // R3: month stays within 1..12
    p_mon_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.live.mon >= 8'h01) && (state_q.live.mon <= MON_MAX))
        else $error("p_mon_range_r3");

    // R4: weekday stays within 0..6
    p_wday_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.live.wday <= WDAY_MAX)
        else $error("p_wday_range_r4");

    // R9: a cleared power-up flag does not come back
    p_pwr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && bus_wdata[S_PWR]) |=> !state_q.stat[S_PWR])
        else $error("p_pwr_clear_r9");

    // R10: the alarm flag only rises after an advancing tick
    p_alarm_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.stat[S_ALM]) |-> $past(sec_tick && state_q.ctrl[C_RUN]))
        else $error("p_alarm_src_r10");

endmodule

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;
    import rtc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sec_tick = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_rdata;
    logic              irq;

    always #5 clk = ~clk;

    bcd_rtc u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    int vectors = 0;
    int miscompares = 0;
    bit run_chk = 0;
    logic [7:0] last_rd;

    // reference model state
    logic [7:0] m_tm [7] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};
    logic [7:0] m_sh [7] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};
    logic [7:0] m_alm [6] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    logic [7:0] m_ctrl = 8'h00, m_st = 8'h80, m_ien = 8'h00, m_clo = 8'h00, m_chi = 8'h00;

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    function automatic logic m_irq();
        logic ev;
        ev = m_st[2 + int'(m_ien[1:0])];
        return (m_st[6] & m_ien[3]) | (ev & m_ien[2]);
    endfunction

    function automatic logic [7:0] m_read(input int a);
        if (a < 7) return m_sh[a];
        if (a < 13) return m_alm[a - 7];
        case (a)
            13: return m_ctrl;
            14: return {m_st[7:2], m_ctrl[0], 1'b0};
            15: return m_ien & 8'h0F;
            16: return m_clo;
            17: return m_chi;
            default: return 8'h00;
        endcase
    endfunction

    // advance one second; returns the status bits the tick sets
    function automatic logic [7:0] m_adv();
        int s, mi, h, dd, mo, y, w;
        bit pm, eday;
        logic [7:0] setm;
        setm = 8'h04;
        eday = 0;
        s = b2i(m_tm[0]); mi = b2i(m_tm[1]); dd = b2i(m_tm[3]);
        mo = b2i(m_tm[4]); y = b2i(m_tm[5]); w = int'(m_tm[6]);
        s++;
        if (s == 60) begin
            s = 0; setm[3] = 1; mi++;
            if (mi == 60) begin
                mi = 0; setm[4] = 1;
                if (m_ctrl[3]) begin
                    pm = m_tm[2][7];
                    h = b2i({3'b000, m_tm[2][4:0]});
                    if (h == 11) begin h = 12; eday = pm; pm = !pm; end
                    else if (h == 12) h = 1;
                    else h++;
                    m_tm[2] = i2b(h) | {pm, 7'h00};
                end else begin
                    h = b2i(m_tm[2]) + 1;
                    if (h == 24) begin h = 0; eday = 1; end
                    m_tm[2] = i2b(h);
                end
            end
        end
        if (eday) begin
            setm[5] = 1;
            dd++;
            if (dd > dim(mo, y)) begin
                dd = 1; mo++;
                if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
            end
            w = (w + 1) % 7;
        end
        m_tm[0] = i2b(s); m_tm[1] = i2b(mi); m_tm[3] = i2b(dd);
        m_tm[4] = i2b(mo); m_tm[5] = i2b(y); m_tm[6] = 8'(w);
        if (m_tm[0] == m_alm[0] && m_tm[1] == m_alm[1] && m_tm[2] == m_alm[2] &&
            m_tm[3] == m_alm[3] && m_tm[4] == m_alm[4] && m_tm[5] == m_alm[5])
            setm[6] = 1;
        return setm;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // R11: irq compared against the model on every clock
    always @(negedge clk) begin
        if (run_chk) chk("R11 irq", {7'h0, irq}, {7'h0, m_irq()});
    end

    task automatic cyc(input bit t, input bit w, input bit r, input int a,
                       input logic [7:0] dv, input string tag);
        logic [7:0] exp_rd, old_tm [7], setm, clr;
        bit old_run;
        sec_tick = t; bus_wr = w; bus_rd = r; bus_addr = 5'(a); bus_wdata = dv;
        @(posedge clk);
        #1;
        exp_rd = m_read(a);
        old_tm = m_tm;
        old_run = m_ctrl[0];
        setm = 8'h00; clr = 8'h00;
        if (t && old_run) setm = m_adv();
        if (w) begin
            if (a < 7) begin
                if (!old_run) m_tm[a] = dv;
            end else if (a < 13) m_alm[a - 7] = dv;
            else case (a)
                13: begin
                    m_ctrl = {dv[7], 1'b0, dv[5:0]};
                    if (dv[6]) m_sh = old_tm;
                end
                14: clr = dv;
                15: m_ien = dv & 8'h0F;
                16: m_clo = dv;
                17: m_chi = dv;
                default: ;
            endcase
        end
        m_st = ((m_st & ~clr) | setm) & 8'hFC;
        sec_tick = 0; bus_wr = 0; bus_rd = 0;
        @(negedge clk);
        if (r) begin
            last_rd = bus_rdata;
            chk(tag, bus_rdata, exp_rd);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cyc(0, 1, 0, a, d, "");
    endtask

    task automatic rd(input int a, input string tag);
        cyc(0, 0, 1, a, 8'h00, tag);
    endtask

    task automatic tk();
        cyc(1, 0, 0, 0, 8'h00, "");
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, d, mo, y, wd);
        wr(13, m_ctrl & 8'hFE);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y); wr(6, wd);
        wr(13, m_ctrl | 8'h01);
    endtask

    task automatic snap(input string tag);
        wr(13, m_ctrl | 8'h40);
        for (int a = 0; a < 7; a++) rd(a, tag);
    endtask

    task automatic day_case(input logic [7:0] d, mo, y, ed, em, ey);
        set_time(8'h59, 8'h59, 8'h23, d, mo, y, 8'h00);
        tk();
        snap("R3 calendar");
        rd(3, "R3 day");   chk("R3 day literal", last_rd, ed);
        rd(4, "R3 month"); chk("R3 month literal", last_rd, em);
        rd(5, "R3 year");  chk("R3 year literal", last_rd, ey);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired got running exp finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_chk = 1;
        @(negedge clk);

        // R1 reset values
        rd(14, "R1 status"); chk("R1 status literal", last_rd, 8'h80);
        rd(13, "R1 control"); chk("R1 control literal", last_rd, 8'h00);
        rd(15, "R1 interrupt"); chk("R1 irq", {7'h0, irq}, 8'h00);

        // R9 clearing only the alarm flag keeps power-up
        wr(14, 8'h40);
        rd(14, "R9 keep"); chk("R9 power-up kept", last_rd, 8'h80);

        // R2 R3 R4 full year wrap
        set_time(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06);
        tk(); tk();
        snap("R2 wrap");
        rd(0, "R2 sec"); chk("R2 sec literal", last_rd, 8'h00);
        rd(2, "R2 hour"); chk("R2 hour literal", last_rd, 8'h00);
        rd(5, "R3 year"); chk("R3 year wrap literal", last_rd, 8'h00);
        rd(6, "R4 wday"); chk("R4 weekday wrap literal", last_rd, 8'h00);

        // R3 month lengths and leap years
        day_case(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
        day_case(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
        day_case(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
        day_case(8'h30, 8'h04, 8'h23, 8'h01, 8'h05, 8'h23);
        day_case(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);

        // R5 12-hour mode
        wr(13, 8'h08);
        set_time(8'h59, 8'h59, 8'h11, 8'h15, 8'h06, 8'h25, 8'h02);
        tk(); snap("R5 am-pm");
        rd(2, "R5 hour"); chk("R5 noon literal", last_rd, 8'h92);
        set_time(8'h59, 8'h59, 8'h92, 8'h15, 8'h06, 8'h25, 8'h02);
        tk(); snap("R5 one");
        rd(2, "R5 hour"); chk("R5 one pm literal", last_rd, 8'h81);
        set_time(8'h59, 8'h59, 8'h91, 8'h15, 8'h06, 8'h25, 8'h02);
        tk(); snap("R5 midnight");
        rd(2, "R5 hour"); chk("R5 midnight literal", last_rd, 8'h12);
        rd(3, "R5 day"); chk("R5 day step literal", last_rd, 8'h16);
        wr(13, 8'h00);

        // R6 run gating
        set_time(8'h10, 8'h20, 8'h05, 8'h03, 8'h07, 8'h25, 8'h02);
        wr(13, 8'h00);
        tk(); tk();
        snap("R6 stopped");
        rd(0, "R6 sec"); chk("R6 stopped literal", last_rd, 8'h10);
        wr(13, 8'h01);
        wr(0, 8'h45);
        tk();
        snap("R6 running");
        rd(0, "R6 sec"); chk("R6 write ignored literal", last_rd, 8'h11);

        // R7 shadow holds between captures
        tk(); tk();
        rd(0, "R7 shadow"); chk("R7 shadow literal", last_rd, 8'h11);
        snap("R7 capture");
        rd(0, "R7 sec"); chk("R7 recapture literal", last_rd, 8'h13);
        rd(13, "R7 control"); chk("R7 capture bit reads 0", last_rd, 8'h01);

        // R8 event flags and run bit
        wr(14, 8'hFF);
        rd(14, "R8 cleared"); chk("R8 run bit literal", last_rd, 8'h02);
        tk();
        rd(14, "R8 second"); chk("R8 second flag literal", last_rd, 8'h06);

        // R9 a set beats a clear in the same cycle
        cyc(1, 1, 0, 14, 8'hFF, "");
        rd(14, "R9 set wins"); chk("R9 set wins literal", last_rd, 8'h06);

        // R10 R11 alarm
        set_time(8'h57, 8'h30, 8'h10, 8'h05, 8'h05, 8'h25, 8'h01);
        wr(7, 8'h59); wr(8, 8'h30); wr(9, 8'h10);
        wr(10, 8'h05); wr(11, 8'h05); wr(12, 8'h25);
        wr(14, 8'hFF);
        wr(15, 8'h08);
        tk();
        rd(14, "R10 early"); chk("R10 no alarm yet", last_rd, 8'h06);
        tk();
        rd(14, "R10 match"); chk("R10 alarm flag literal", last_rd, 8'h46);
        chk("R11 alarm irq", {7'h0, irq}, 8'h01);
        wr(14, 8'h40);
        chk("R11 alarm irq cleared", {7'h0, irq}, 8'h00);
        wr(14, 8'hFF);
        wr(15, 8'h05);
        chk("R11 timer idle", {7'h0, irq}, 8'h00);
        tk();
        chk("R11 minute irq", {7'h0, irq}, 8'h01);

        // R12 storage read-back
        wr(16, 8'hA5); wr(17, 8'h3C);
        rd(16, "R12 low"); chk("R12 low literal", last_rd, 8'hA5);
        rd(17, "R12 high"); chk("R12 high literal", last_rd, 8'h3C);
        rd(9, "R12 alarm hour"); chk("R12 alarm literal", last_rd, 8'h10);
        wr(15, 8'hFF);
        rd(15, "R12 interrupt"); chk("R12 interrupt literal", last_rd, 8'h0F);
        rd(31, "R12 unmapped"); chk("R12 unmapped literal", last_rd, 8'h00);
        wr(15, 8'h00);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule